// File: doc/BRIEF.md
# Two-Source Line Interrupt Generator

This block watches two general-purpose input lines and turns qualified activity on them into a single shared interrupt request for a host bus. For each source, software chooses three things: whether the source may raise the request, whether it responds to a level or to an edge, and which polarity counts as active. The host bus logic owns the register protocol. It passes configuration writes in as a strobe with a data word, and it passes write-one-to-clear writes of the status register in as a per-source pulse.

Each line goes through a two-flop synchroniser before any detection. In edge mode a qualified edge sets a sticky status bit, which stays set until software clears it. In level mode the status bit tracks the qualified level. The request output is registered, and it is high while any enabled source has its status bit set. A change of a source's mode or polarity wipes its status bit, so that reconfiguring a source cannot leave a stale or false interrupt behind.

Top module: `chan_irq_gen`

## Requirements
- R1: Configuration word layout: source k uses bits [3k+2:3k] of `cfg_wdata_i`. Bit 3k is enable, bit 3k+1 selects edge mode (1) or level mode (0), and bit 3k+2 selects active-high or rising (1) versus active-low or falling (0). The word loads on `cfg_we_i`. Reset sets every field to zero and holds `status_o` and `irq_o` low.
- R2: An input change applied between clock edges first shows on `status_o` after the third rising edge that follows it, and on `irq_o` after the fourth.
- R3: In level mode, a source's status bit equals 1 when its synchronised input matches the selected polarity, and 0 otherwise.
- R4: In level mode, a clear pulse leaves the status bit at 1 while the qualified level remains active.
- R5: In edge mode, a qualified edge sets the status bit, and the bit stays set after the input returns. An edge of the opposite direction does not set it.
- R6: In edge mode, a clear pulse on a source clears its status bit at the next edge. The request falls one cycle after that.
- R7: In edge mode, if a qualified edge is detected in the same cycle as a clear pulse, the status bit stays set.
- R8: A source with its enable bit at 0 never raises `irq_o`, but its status bit is still updated.
- R9: A configuration write that changes a source's mode or polarity clears that source's status bit at the same edge. A write that leaves both unchanged keeps the bit.
- R10: `irq_o` is a register that holds the OR, over both sources, of status AND enable, sampled one cycle earlier.
- R11: In edge mode with polarity 0, a falling edge sets the status bit and a rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_i | input | 2 | Asynchronous input lines, one per source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 6 | Configuration word, 3 bits per source |
| clr_i | input | 2 | Write-one-to-clear pulse per source |
| status_o | output | 2 | Status bit per source |
| irq_o | output | 1 | Shared interrupt request |

## Verification
A line change first appears in status three edges after it is applied: two edges for the synchroniser and one for the status register. It reaches the request one edge after that. Clear pulses and configuration writes act on status at the very edge that samples them. The bench drives every stimulus on a falling edge. For the latency test it counts rising edges exactly and samples at the following falling edge. For steady-state table entries it waits six cycles, which is longer than the full four-edge path.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
  typedef struct packed {
    logic act_high;
    logic edge_mode;
    logic enable;
  } src_cfg_t;

  localparam int unsigned CFG_W = $bits(src_cfg_t);
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/src_detect.sv
module src_detect
  import chan_irq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sync_i,
  input  src_cfg_t cfg_i,
  input  logic     cfg_chg_i,
  input  logic     clr_i,
  output logic     status_o
);
  logic prev_q, status_q, status_d;
  logic lvl_act, edge_hit;

  assign lvl_act  = (sync_i == cfg_i.act_high);
  assign edge_hit = cfg_i.act_high ? (sync_i & ~prev_q) : (~sync_i & prev_q);

  always_comb begin
    if (cfg_chg_i)            status_d = 1'b0;
    else if (cfg_i.edge_mode) status_d = edge_hit | (status_q & ~clr_i);
    else                      status_d = lvl_act;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= sync_i;
      status_q <= status_d;
    end
  end

  assign status_o = status_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.edge_mode && edge_hit && clr_i && !cfg_chg_i) |=> status_o);

  a_r9_cfg_change_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg_i |=> !status_o);

  a_r3_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.edge_mode && !cfg_chg_i) |=>
      (status_o == ($past(sync_i) == $past(cfg_i.act_high))));

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.edge_mode && status_o && !clr_i && !cfg_chg_i) |=> status_o);
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] status_i,
  input  logic [N_SRC-1:0] enable_i,
  output logic             irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & enable_i);
  end

  assign irq_o = irq_q;

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_i & enable_i)) |=> !irq_o);

  a_r10_enabled_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_i & enable_i)) |=> irq_o);
endmodule

// File: rtl/chan_irq_gen.sv
module chan_irq_gen
  import chan_irq_pkg::*;
#(
  parameter int unsigned N_SRC       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W     = N_SRC * CFG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  gpio_i,
  input  logic              cfg_we_i,
  input  logic [WORD_W-1:0] cfg_wdata_i,
  input  logic [N_SRC-1:0]  clr_i,
  output logic [N_SRC-1:0]  status_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] enable;
  src_cfg_t         cfg_q   [N_SRC];
  src_cfg_t         cfg_new [N_SRC];
  logic [N_SRC-1:0] cfg_chg;

  line_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (gpio_i),
    .q_o   (sync_q)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign cfg_new[k] = src_cfg_t'(cfg_wdata_i[k*CFG_W +: CFG_W]);
    assign cfg_chg[k] = cfg_we_i &&
                        ((cfg_new[k].edge_mode != cfg_q[k].edge_mode) ||
                         (cfg_new[k].act_high  != cfg_q[k].act_high));
    assign enable[k]  = cfg_q[k].enable;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q[k] <= '0;
      else if (cfg_we_i) cfg_q[k] <= cfg_new[k];
    end

    src_detect u_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sync_i   (sync_q[k]),
      .cfg_i    (cfg_q[k]),
      .cfg_chg_i(cfg_chg[k]),
      .clr_i    (clr_i[k]),
      .status_o (status_o[k])
    );
  end

  irq_merge #(.N_SRC(N_SRC)) u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .status_i(status_o),
    .enable_i(enable),
    .irq_o   (irq_o)
  );

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!irq_o || rst_ni));
endmodule

// File: tb/tb_chan_irq_gen.sv
`timescale 1ns/1ps
module tb_chan_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] gpio = '0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [1:0] clr = '0;
  logic [1:0] status;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_irq_gen dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .gpio_i     (gpio),
    .cfg_we_i   (cfg_we),
    .cfg_wdata_i(cfg_wdata),
    .clr_i      (clr),
    .status_o   (status),
    .irq_o      (irq)
  );

  // fields: [10:5] cfg {src1,src0}, [4:3] gpio, [2:1] status, [0] irq
  localparam int NV = 6;
  localparam logic [10:0] VEC [NV] = '{
    11'b000101_01_11_1,
    11'b000101_10_00_0,
    11'b101001_00_01_1,
    11'b101000_10_11_1,
    11'b100000_10_11_0,
    11'b001101_11_01_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [5:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr(input logic [1:0] m);
    clr = m;
    @(posedge clk);
    @(negedge clk);
    clr = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 2'b00);
    chk("R1 reset irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R8 level-mode table
    for (int i = 0; i < NV; i++) begin
      gpio = VEC[i][4:3];
      write_cfg(VEC[i][10:5]);
      wait_n(6);
      chk($sformatf("R3 R1 vec%0d status", i), status, VEC[i][2:1]);
      chk($sformatf("R8 R10 vec%0d irq", i), irq, VEC[i][0]);
    end

    // R2 latency: src0 level active-high enabled
    gpio = 2'b00;
    write_cfg(6'b000_101);
    wait_n(6);
    gpio = 2'b01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R2 status after 2 edges", status[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R2 status after 3 edges", status[0], 1'b1);
    chk("R2 irq after 3 edges", irq, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R10 irq after 4 edges", irq, 1'b1);

    // R4 clear ignored while level active
    pulse_clr(2'b01);
    chk("R4 level clear no effect", status[0], 1'b1);

    // R5 rising edge mode
    write_cfg(6'b000_111);
    gpio = 2'b00;
    wait_n(6);
    chk("R5 falling ignored in rising mode", status[0], 1'b0);
    gpio = 2'b01;
    wait_n(6);
    chk("R5 rising sets", status[0], 1'b1);
    gpio = 2'b00;
    wait_n(6);
    chk("R5 sticky after release", status[0], 1'b1);

    // R6 clear
    pulse_clr(2'b01);
    chk("R6 clear status", status[0], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R6 irq falls", irq, 1'b0);

    // R7 edge and clear in same cycle
    gpio = 2'b01;
    wait_n(6);
    gpio = 2'b00;
    wait_n(6);
    gpio = 2'b01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    pulse_clr(2'b01);
    chk("R7 set wins over clear", status[0], 1'b1);

    // R11 falling-edge mode on src1, src0 masked level
    gpio = 2'b00;
    write_cfg(6'b011_000);
    wait_n(6);
    gpio = 2'b10;
    wait_n(6);
    chk("R11 rising ignored", status[1], 1'b0);
    gpio = 2'b00;
    wait_n(6);
    chk("R11 falling sets", status[1], 1'b1);
    chk("R11 irq raised", irq, 1'b1);

    // R9 config change clears
    write_cfg(6'b011_000);
    chk("R9 same config keeps", status[1], 1'b1);
    write_cfg(6'b111_000);
    chk("R9 polarity change clears", status[1], 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq drops", irq, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule